// File: doc/BRIEF.md
# Majority-Vote Read Combiner

This block forms the data word returned by a similarity-addressed associative memory. Counter storage and address matching sit outside it. While a read scans the memory, the block receives one counter vector per clock beat. Each vector carries one small signed counter per output bit position, plus a flag that says whether the address matcher chose that row. The block adds the counters of every chosen row into one wide signed accumulator per bit position.

When the scan ends, each accumulator is reduced to one output bit by its sign. An exact zero is settled by a coin flip that comes from an internal shift-register sequence. The sequence starts from a seed input, so its outcomes can be predicted. Each result comes with a one-cycle valid pulse, the raw per-position sums, and a flag that is set when no row was chosen at all.

Top module: `sdm_vote_read`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `res_valid`, `res_word`, `res_sums` and `res_empty` are all zero.
- R2: Lane i of `beat_cnt` (bits [8i+7:8i] with the default counter width) is a two's-complement counter. Lane i of `res_sums` (bits [21i+20:21i] with the default parameters) is the two's-complement sum of lane i over every chosen beat of the scan.
- R3: A beat presented with `beat_sel` low leaves every accumulator unchanged.
- R4: A lane whose sum is greater than zero gives a 1 in the same bit of `res_word`.
- R5: A lane whose sum is less than zero gives a 0 in the same bit of `res_word`.
- R6: A lane whose sum is exactly zero gives bit (i mod 32) of the 32-bit coin register as it stands in the `scan_end` cycle. Reset loads the register with `seed` (or with 1 if `seed` is zero). Each `scan_end` moves the register one step: shift right by one, then XOR with the mask 0xB4BCD35C if the bit shifted out was 1.
- R7: `scan_start` clears every accumulator. A chosen beat in the same cycle becomes the first contribution.
- R8: Results include a chosen beat in the `scan_end` cycle. `res_valid` is high for exactly the cycle after each `scan_end`. All result outputs hold their values until the next `scan_end`.
- R9: `res_empty` is 1 with a result exactly when no chosen beat arrived since the last `scan_start`. In that case every sum is zero.
- R10: With LOC_MAX chosen beats all at +127 or all at -127, the lane sums reach +LOC_MAX*127 and -LOC_MAX*127 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the coin register from `seed` |
| seed | input | 32 | Start value of the coin register |
| scan_start | input | 1 | Clears the accumulators at the start of a read |
| beat_valid | input | 1 | A counter vector is present this cycle |
| beat_sel | input | 1 | The present row was chosen by the address matcher |
| beat_cnt | input | WORD_W*CNT_W | One signed counter per output bit position |
| scan_end | input | 1 | Last cycle of the read; results are captured at this edge |
| res_valid | output | 1 | One-cycle pulse when a new result is present |
| res_word | output | WORD_W | Thresholded data word |
| res_sums | output | WORD_W*ACC_W | Signed per-position sums |
| res_empty | output | 1 | No row was chosen during the scan |

## Verification
The hardest case to reach from the ports is a completely full scan: LOC_MAX chosen rows whose counters all sit at the same extreme, so that the accumulators land exactly on their outer bound. The bench gets there by streaming 8192 beats, with one lane pinned at +127 and another at -127. The remaining lanes are left at zero, so the same scan also exercises the tie path. The bench predicts the tie bits by stepping its own copy of the coin register from the known seed. Ties also occur in the smaller scans, where chosen beats are built so that their counters cancel exactly.

// File: rtl/sdm_vote_pkg.sv
package sdm_vote_pkg;

    localparam int COIN_W = 32;

    typedef enum logic [1:0] {
        SIGN_NEG  = 2'd0,
        SIGN_ZERO = 2'd1,
        SIGN_POS  = 2'd2
    } vote_sign_e;

    // One step of a right-shifting Galois sequence
    function automatic logic [COIN_W-1:0] coin_step(
        input logic [COIN_W-1:0] s,
        input logic [COIN_W-1:0] mask
    );
        logic [COIN_W-1:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ mask;
        return r;
    endfunction

endpackage

// File: rtl/sdm_vote_coin.sv
module sdm_vote_coin
    import sdm_vote_pkg::*;
#(
    parameter logic [COIN_W-1:0] MASK = 32'hB4BCD35C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COIN_W-1:0] seed_i,
    input  logic              step_i,
    output logic [COIN_W-1:0] state_o
);
    logic [COIN_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= (seed_i == '0) ? {{(COIN_W-1){1'b0}}, 1'b1} : seed_i;
        end else if (step_i) begin
            state_q <= coin_step(state_q, MASK);
        end
    end

    assign state_o = state_q;

    // R6
    coin_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/sdm_vote_lane.sv
module sdm_vote_lane
    import sdm_vote_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int ACC_W   = 21,
    parameter int LOC_MAX = 8192
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic                    add_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic                    cap_i,
    input  logic                    tie_i,
    output logic signed [ACC_W-1:0] sum_o,
    output logic                    bit_o
);
    localparam longint LIM = longint'(LOC_MAX) * ((longint'(1) << (CNT_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] LIM_P = ACC_W'(LIM);

    logic signed [ACC_W-1:0] acc_q, acc_nx, base, ext;
    vote_sign_e              sign;

    always_comb begin
        base   = clr_i ? '0 : acc_q;
        ext    = {{(ACC_W-CNT_W){cnt_i[CNT_W-1]}}, cnt_i};
        acc_nx = add_i ? base + ext : base;
        if (acc_nx == '0)       sign = SIGN_ZERO;
        else if (acc_nx[ACC_W-1]) sign = SIGN_NEG;
        else                    sign = SIGN_POS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sum_o <= '0;
            bit_o <= 1'b0;
        end else begin
            acc_q <= acc_nx;
            if (cap_i) begin
                sum_o <= acc_nx;
                unique case (sign)
                    SIGN_POS:  bit_o <= 1'b1;
                    SIGN_NEG:  bit_o <= 1'b0;
                    default:   bit_o <= tie_i;
                endcase
            end
        end
    end

    // R4
    pos_vote_chk: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> (sum_o > 0) ? bit_o : 1'b1);
    // R5
    neg_vote_chk: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> (sum_o < 0) ? !bit_o : 1'b1);
    // R10
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_q <= LIM_P) && (acc_q >= -LIM_P));

endmodule

// File: rtl/sdm_vote_read.sv
module sdm_vote_read
    import sdm_vote_pkg::*;
#(
    parameter int WORD_W  = 256,
    parameter int CNT_W   = 8,
    parameter int LOC_MAX = 8192,
    parameter logic [COIN_W-1:0] COIN_MASK = 32'hB4BCD35C,
    localparam int ACC_W  = $clog2(LOC_MAX * ((1 << (CNT_W-1)) - 1) + 1) + 1,
    localparam int SEL_W  = $clog2(LOC_MAX + 1) + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [COIN_W-1:0]         seed,
    input  logic                      scan_start,
    input  logic                      beat_valid,
    input  logic                      beat_sel,
    input  logic [WORD_W*CNT_W-1:0]   beat_cnt,
    input  logic                      scan_end,
    output logic                      res_valid,
    output logic [WORD_W-1:0]         res_word,
    output logic [WORD_W*ACC_W-1:0]   res_sums,
    output logic                      res_empty
);
    logic              add;
    logic [COIN_W-1:0] coin;
    logic [SEL_W-1:0]  sel_q, sel_nx;

    assign add = beat_valid && beat_sel;

    sdm_vote_coin #(.MASK(COIN_MASK)) coin_i (
        .clk    (clk),
        .rst    (rst),
        .seed_i (seed),
        .step_i (scan_end),
        .state_o(coin)
    );

    for (genvar g = 0; g < WORD_W; g++) begin : g_lane
        logic signed [ACC_W-1:0] lane_sum;
        sdm_vote_lane #(.CNT_W(CNT_W), .ACC_W(ACC_W), .LOC_MAX(LOC_MAX)) lane_i (
            .clk   (clk),
            .rst   (rst),
            .clr_i (scan_start),
            .add_i (add),
            .cnt_i (beat_cnt[g*CNT_W +: CNT_W]),
            .cap_i (scan_end),
            .tie_i (coin[g % COIN_W]),
            .sum_o (lane_sum),
            .bit_o (res_word[g])
        );
        assign res_sums[g*ACC_W +: ACC_W] = lane_sum;
    end

    always_comb begin
        sel_nx = scan_start ? '0 : sel_q;
        if (add && sel_nx != '1) sel_nx = sel_nx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            res_valid <= 1'b0;
            res_empty <= 1'b0;
        end else begin
            sel_q     <= sel_nx;
            res_valid <= scan_end;
            if (scan_end) res_empty <= (sel_nx == '0);
        end
    end

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_end |=> $stable(res_word) && $stable(res_sums));
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        scan_end |=> res_valid);
    // R9
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        res_empty |-> (res_sums == '0));
    // R10
    sel_limit_chk: assert property (@(posedge clk) disable iff (rst)
        sel_q <= SEL_W'(LOC_MAX));

endmodule

// File: tb/sdm_vote_read_tb_top.sv
module sdm_vote_read_tb_top;
    localparam int W  = 16;
    localparam int CW = 8;
    localparam int LM = 8192;
    localparam int AW = 21;
    localparam logic [31:0] MASK = 32'hB4BCD35C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] seed = 32'h1234_5679;
    logic scan_start = 1'b0, beat_valid = 1'b0, beat_sel = 1'b0, scan_end = 1'b0;
    logic [W*CW-1:0] beat_cnt = '0;
    logic res_valid, res_empty;
    logic [W-1:0] res_word;
    logic [W*AW-1:0] res_sums;

    int tests = 0, fails = 0;
    int drv [W];
    longint msum [W];
    logic [31:0] coin_m;

    always #4 clk = ~clk;

    sdm_vote_read #(.WORD_W(W), .CNT_W(CW), .LOC_MAX(LM)) dut_i (
        .clk(clk), .rst(rst), .seed(seed), .scan_start(scan_start),
        .beat_valid(beat_valid), .beat_sel(beat_sel), .beat_cnt(beat_cnt),
        .scan_end(scan_end), .res_valid(res_valid), .res_word(res_word),
        .res_sums(res_sums), .res_empty(res_empty)
    );

    function automatic logic [31:0] mstep(input logic [31:0] s);
        logic [31:0] r = s >> 1;
        if (s[0]) r = r ^ MASK;
        return r;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] s);
        @(negedge clk);
        rst = 1'b1; seed = s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        coin_m = (s == 0) ? 32'd1 : s;
        for (int i = 0; i < W; i++) msum[i] = 0;
    endtask

    task automatic put_beat(input bit sel, input bit start, input bit fin);
        for (int i = 0; i < W; i++) beat_cnt[i*CW +: CW] = CW'(drv[i]);
        beat_valid = 1'b1; beat_sel = sel; scan_start = start; scan_end = fin;
        if (start) for (int i = 0; i < W; i++) msum[i] = 0;
        if (sel) for (int i = 0; i < W; i++) msum[i] += drv[i];
        @(negedge clk);
        beat_valid = 1'b0; beat_sel = 1'b0; scan_start = 1'b0; scan_end = 1'b0;
    endtask

    task automatic end_only();
        scan_end = 1'b1;
        @(negedge clk);
        scan_end = 1'b0;
    endtask

    // Called at the negedge right after the scan_end edge
    task automatic check_result(input string req, input bit empty_exp);
        logic [W-1:0] wexp;
        chk({req, " R8 valid"}, res_valid, 1);
        for (int i = 0; i < W; i++) begin
            if (msum[i] > 0) wexp[i] = 1'b1;
            else if (msum[i] < 0) wexp[i] = 1'b0;
            else wexp[i] = coin_m[i % 32];
            chk({req, " R2 sum"}, longint'($signed(res_sums[i*AW +: AW])), msum[i]);
        end
        chk({req, " R4 R5 R6 word"}, res_word, wexp);
        chk({req, " R9 empty"}, res_empty, empty_exp);
        coin_m = mstep(coin_m);
        @(negedge clk);
        chk({req, " R8 pulse ends"}, res_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 valid", res_valid, 0);
        chk("R1 word", res_word, 0);
        chk("R1 sums", (res_sums == '0) ? 1 : 0, 1);
        chk("R1 empty", res_empty, 0);
    endtask

    task automatic t_mixed();
        // lanes: positive, negative, cancelling, untouched
        for (int i = 0; i < W; i++) drv[i] = (i % 4 == 0) ? 5 : (i % 4 == 1) ? -7 : (i % 4 == 2) ? 9 : 0;
        put_beat(1, 1, 0);
        for (int i = 0; i < W; i++) drv[i] = (i % 4 == 0) ? -2 : (i % 4 == 1) ? 3 : (i % 4 == 2) ? -9 : 0;
        put_beat(1, 0, 0);
        // R3: unselected beat with large values must not count
        for (int i = 0; i < W; i++) drv[i] = (i % 2) ? 127 : -127;
        put_beat(0, 0, 0);
        for (int i = 0; i < W; i++) drv[i] = (i % 4 == 0) ? 1 : (i % 4 == 1) ? -1 : 0;
        put_beat(1, 0, 0);
        end_only();
        check_result("mixed R3", 0);
    endtask

    task automatic t_start_and_end_beats();
        // stale contents from the last scan must be cleared (R7)
        for (int i = 0; i < W; i++) drv[i] = i - 8;
        put_beat(1, 1, 0);
        for (int i = 0; i < W; i++) drv[i] = (i < 8) ? 8 - i : -(i - 7);
        put_beat(1, 0, 1);   // beat in the scan_end cycle counts (R8)
        check_result("R7 R8 edge beats", 0);
    endtask

    task automatic t_empty();
        for (int i = 0; i < W; i++) drv[i] = 100;
        put_beat(0, 1, 0);
        put_beat(0, 0, 0);
        end_only();
        check_result("R9 no selection", 1);
        end_only();
        check_result("R9 R6 second empty", 1);
    endtask

    task automatic t_hold();
        logic [W-1:0] w0;
        logic [W*AW-1:0] s0;
        for (int i = 0; i < W; i++) drv[i] = (i % 3) - 1;
        put_beat(1, 1, 0);
        end_only();
        check_result("R8 hold setup", 0);
        w0 = res_word; s0 = res_sums;
        for (int i = 0; i < W; i++) drv[i] = -50;
        put_beat(1, 0, 0);
        put_beat(1, 0, 0);
        chk("R8 word held", res_word, w0);
        chk("R8 sums held", (res_sums == s0) ? 1 : 0, 1);
        chk("R8 no valid", res_valid, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < W; i++) drv[i] = (i == 0) ? 127 : (i == 1) ? -127 : 0;
        put_beat(1, 1, 0);
        for (int k = 1; k < LM - 1; k++) put_beat(1, 0, 0);
        put_beat(1, 0, 1);
        check_result("R10 full scan", 0);
        chk("R10 upper", msum[0], longint'(LM) * 127);
        chk("R10 lower", msum[1], -longint'(LM) * 127);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset(32'h1234_5679);
        t_reset();
        t_mixed();
        t_start_and_end_beats();
        t_empty();
        t_hold();
        t_full();
        do_reset(32'h0);      // R6: zero seed falls back to 1
        t_reset();
        t_empty();
        t_mixed();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule